// File: doc/BRIEF.md
# Buffered SPI Master with Event Interrupt

This block is an 8-bit SPI master with one word of buffering in each direction. Software writes a byte into a transmit holding register. The byte moves into the shift register as soon as the shifter can accept it. Each byte clocked in from the slave is copied into a receive holding register.

Two status flags record the state of the buffers:

- the transmit holding register is empty;
- a received byte is waiting to be read.

A third status bit records that a received byte was overwritten before it was read.

The block drives one interrupt request line to an external interrupt controller. A flag that becomes set produces a request on that line only if its own enable bit in the control register is 1. Each request is a single-clock pulse issued in the same cycle the flag is set. The line does not say which source raised it, so the handler reads the status register to find the cause.

The register port is a simple synchronous strobe interface with a 2-bit address:

| Address | Register | Access |
|---|---|---|
| 0 | Status | Read; write 1 to bit 2 to clear it |
| 1 | Transmit data | Write |
| 2 | Receive data | Read |
| 3 | Control | Read and write |

Read data is combinational from the address.

Top module: `spi_irq_master`

## Requirements
- R1: After reset the status register (address 0) reads 0x01: bit 0 (transmit empty) is 1, bit 1 (receive full) is 0 and bit 2 (overrun) is 0. The control register (address 3) reads 0x00, irq is 0, spi_cs_n is 1 and spi_sclk is 0.
- R2: A write to address 1 clears status bit 0 at the next clock edge. If the shifter is idle, the byte enters the shift register one clock later. At that edge status bit 0 returns to 1 and spi_cs_n goes low.
- R3: When a byte completes, it is copied to the receive register and status bit 1 is set. A read of address 2 returns that byte and clears status bit 1.
- R4: Each transfer is 8 bits, MSB first, in SPI mode 0. spi_sclk idles low. spi_mosi is valid before each rising edge, and spi_miso is sampled on the rising edge.
- R5: The spi_sclk period is 2*(D+1) clock cycles, where D is control bits 3:0.
- R6: If a byte is pending in the transmit register when a transfer ends, it is loaded in that same cycle. spi_cs_n stays low, and the gap between rising spi_sclk edges stays equal to one period.
- R7: If a byte completes while status bit 1 is already 1, the receive register is overwritten and status bit 2 is set. Writing 1 to status bit 2 clears it; writing 0 leaves it set.
- R8: Control bit 4 enables the transmit-empty request. When it is 1, irq is high for exactly the one cycle in which status bit 0 becomes set by a load; when it is 0 that event gives no pulse.
- R9: Control bit 5 enables the receive-full request. When it is 1, irq is high for exactly the one cycle in which a completed byte sets status bit 1; when it is 0 that event gives no pulse.
- R10: When a load and a byte completion occur in the same cycle and both are enabled, irq gives one single-cycle pulse, and both status bits 0 and 1 read 1 in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | 2 | Register address |
| reg_wr | input | 1 | Write strobe |
| reg_rd | input | 1 | Read strobe (side effects on address 2) |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for reg_addr |
| spi_sclk | output | 1 | Serial clock |
| spi_mosi | output | 1 | Serial data out |
| spi_miso | input | 1 | Serial data in |
| spi_cs_n | output | 1 | Slave select, active low |
| irq | output | 1 | Shared interrupt request pulse |

## Verification
A transfer that ends while a second byte is waiting is the point where the receive-full and transmit-empty events land on the same clock edge. The bench provokes it by writing the second byte while the first is still shifting, with both enables set.

At the cycle the slave model sees the last falling edge, the bench requires irq high and both status flags set. One cycle later it requires irq low. Over the whole stream it expects exactly three pulses, with spi_cs_n held low and no stretched spi_sclk period at the byte boundary.

// File: rtl/spi_irq_pkg.sv
package spi_irq_pkg;

  localparam logic [1:0] A_STAT = 2'd0;
  localparam logic [1:0] A_TXD  = 2'd1;
  localparam logic [1:0] A_RXD  = 2'd2;
  localparam logic [1:0] A_CTL  = 2'd3;

  localparam int unsigned B_TXE = 0;
  localparam int unsigned B_RXF = 1;
  localparam int unsigned B_OVR = 2;
  localparam int unsigned B_TIE = 4;
  localparam int unsigned B_RIE = 5;

  // clock cycles per half period of the serial clock
  function automatic int unsigned half_cycles(input int unsigned div);
    return div + 1;
  endfunction

  // any enabled source fires
  function automatic logic req_any(input logic tx_ev, input logic tie,
                                   input logic rx_ev, input logic rie);
    return (tx_ev & tie) | (rx_ev & rie);
  endfunction

endpackage

// File: rtl/spi_irq_shifter.sv
module spi_irq_shifter #(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned DIV_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [DATA_W-1:0] load_data,
  input  logic [DIV_W-1:0]  div,
  input  logic              miso,
  output logic              sclk,
  output logic              mosi,
  output logic              cs_n,
  output logic              ready,
  output logic              done,
  output logic [DATA_W-1:0] rx_word
);
  localparam int unsigned BIT_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;
  localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(DATA_W - 1);

  logic              busy;
  logic              sclk_q;
  logic [DIV_W-1:0]  cnt;
  logic [BIT_W-1:0]  bitc;
  logic [DATA_W-1:0] tx_sh;
  logic [DATA_W-1:0] rx_sh;

  logic tick, rise, fall, last;

  assign tick = busy && (cnt >= div);
  assign rise = tick && !sclk_q;
  assign fall = tick && sclk_q;
  assign last = fall && (bitc == LAST_BIT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy   <= 1'b0;
      sclk_q <= 1'b0;
      cnt    <= '0;
      bitc   <= '0;
      tx_sh  <= '0;
      rx_sh  <= '0;
    end else if (load) begin
      busy   <= 1'b1;
      sclk_q <= 1'b0;
      cnt    <= '0;
      bitc   <= '0;
      tx_sh  <= load_data;
      if (rise) rx_sh <= {rx_sh[DATA_W-2:0], miso};
    end else if (busy) begin
      cnt <= tick ? '0 : cnt + 1'b1;
      if (rise) begin
        sclk_q <= 1'b1;
        rx_sh  <= {rx_sh[DATA_W-2:0], miso};
      end
      if (fall) begin
        sclk_q <= 1'b0;
        if (last) begin
          busy <= 1'b0;
        end else begin
          bitc  <= bitc + 1'b1;
          tx_sh <= {tx_sh[DATA_W-2:0], 1'b0};
        end
      end
    end
  end

  assign sclk    = sclk_q;
  assign mosi    = tx_sh[DATA_W-1];
  assign cs_n    = !busy;
  assign ready   = !busy || last;
  assign done    = last;
  assign rx_word = rx_sh;

endmodule

// File: rtl/spi_irq_regs.sv
module spi_irq_regs
  import spi_irq_pkg::*;
#(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned DIV_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        addr,
  input  logic              wr,
  input  logic              rd,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  input  logic              sh_ready,
  input  logic              sh_done,
  input  logic [DATA_W-1:0] sh_rx_word,
  output logic              sh_load,
  output logic [DATA_W-1:0] sh_load_data,
  output logic [DIV_W-1:0]  div,
  output logic              tie,
  output logic              rie,
  output logic              txe,
  output logic              rxf,
  output logic              ovr,
  output logic              wr_txd,
  output logic              ev_tx,
  output logic              ev_rx
);
  logic [DATA_W-1:0] tx_buf;
  logic [DATA_W-1:0] rx_buf;
  logic              wr_stat, wr_ctl, rd_rxd;

  assign wr_txd  = wr && (addr == A_TXD);
  assign wr_stat = wr && (addr == A_STAT);
  assign wr_ctl  = wr && (addr == A_CTL);
  assign rd_rxd  = rd && (addr == A_RXD);

  assign sh_load      = !txe && sh_ready;
  assign sh_load_data = tx_buf;
  assign ev_tx        = sh_load && !wr_txd;
  assign ev_rx        = sh_done;

  function automatic logic [DATA_W-1:0] pack_status(input logic e, input logic f,
                                                    input logic o);
    logic [DATA_W-1:0] s;
    s        = '0;
    s[B_TXE] = e;
    s[B_RXF] = f;
    s[B_OVR] = o;
    return s;
  endfunction

  function automatic logic [DATA_W-1:0] pack_ctl(input logic [DIV_W-1:0] d,
                                                 input logic te, input logic re);
    logic [DATA_W-1:0] c;
    c            = '0;
    c[DIV_W-1:0] = d;
    c[B_TIE]     = te;
    c[B_RIE]     = re;
    return c;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      txe    <= 1'b1;
      rxf    <= 1'b0;
      ovr    <= 1'b0;
      tx_buf <= '0;
      rx_buf <= '0;
      div    <= '0;
      tie    <= 1'b0;
      rie    <= 1'b0;
    end else begin
      if (wr_txd) begin
        tx_buf <= wdata;
        txe    <= 1'b0;
      end else if (sh_load) begin
        txe <= 1'b1;
      end
      if (sh_done) begin
        rx_buf <= sh_rx_word;
        rxf    <= 1'b1;
      end else if (rd_rxd) begin
        rxf <= 1'b0;
      end
      if (sh_done && rxf) ovr <= 1'b1;
      else if (wr_stat && wdata[B_OVR]) ovr <= 1'b0;
      if (wr_ctl) begin
        div <= wdata[DIV_W-1:0];
        tie <= wdata[B_TIE];
        rie <= wdata[B_RIE];
      end
    end
  end

  always_comb begin
    case (addr)
      A_STAT:  rdata = pack_status(txe, rxf, ovr);
      A_RXD:   rdata = rx_buf;
      A_CTL:   rdata = pack_ctl(div, tie, rie);
      default: rdata = '0;
    endcase
  end

endmodule

// File: rtl/spi_irq_intgen.sv
module spi_irq_intgen
  import spi_irq_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic ev_tx,
  input  logic ev_rx,
  input  logic tie,
  input  logic rie,
  output logic irq
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq <= 1'b0;
    else        irq <= req_any(ev_tx, tie, ev_rx, rie);
  end
endmodule

// File: rtl/spi_irq_master.sv
module spi_irq_master #(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned DIV_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        reg_addr,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              spi_sclk,
  output logic              spi_mosi,
  input  logic              spi_miso,
  output logic              spi_cs_n,
  output logic              irq
);
  logic              sh_ready, sh_done, sh_load;
  logic [DATA_W-1:0] sh_rx_word, sh_load_data;
  logic [DIV_W-1:0]  ctl_div;
  logic              ctl_tie, ctl_rie;
  logic              st_txe, st_rxf, st_ovr;
  logic              wr_txd, ev_tx_set, ev_rx_set;

  spi_irq_regs #(.DATA_W(DATA_W), .DIV_W(DIV_W)) regs_i (
    .clk(clk), .rst_n(rst_n), .addr(reg_addr), .wr(reg_wr), .rd(reg_rd),
    .wdata(reg_wdata), .rdata(reg_rdata),
    .sh_ready(sh_ready), .sh_done(sh_done), .sh_rx_word(sh_rx_word),
    .sh_load(sh_load), .sh_load_data(sh_load_data),
    .div(ctl_div), .tie(ctl_tie), .rie(ctl_rie),
    .txe(st_txe), .rxf(st_rxf), .ovr(st_ovr),
    .wr_txd(wr_txd), .ev_tx(ev_tx_set), .ev_rx(ev_rx_set)
  );

  spi_irq_shifter #(.DATA_W(DATA_W), .DIV_W(DIV_W)) shift_i (
    .clk(clk), .rst_n(rst_n), .load(sh_load), .load_data(sh_load_data),
    .div(ctl_div), .miso(spi_miso), .sclk(spi_sclk), .mosi(spi_mosi),
    .cs_n(spi_cs_n), .ready(sh_ready), .done(sh_done), .rx_word(sh_rx_word)
  );

  spi_irq_intgen intgen_i (
    .clk(clk), .rst_n(rst_n), .ev_tx(ev_tx_set), .ev_rx(ev_rx_set),
    .tie(ctl_tie), .rie(ctl_rie), .irq(irq)
  );

endmodule

// File: rtl/spi_irq_checker.sv
module spi_irq_checker (
  input logic clk,
  input logic rst_n,
  input logic irq,
  input logic cs_n,
  input logic sclk,
  input logic ev_tx,
  input logic ev_rx,
  input logic txe,
  input logic rxf,
  input logic ovr,
  input logic tie,
  input logic rie
);
  // R8 R9: every pulse traces back to an enabled event one cycle earlier
  a_r8_irq_has_cause: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> $past((ev_tx && tie) || (ev_rx && rie)));

  // R2: a load that is not overwritten leaves the transmit flag set
  a_r2_load_sets_txe: assert property (@(posedge clk) disable iff (!rst_n)
    ev_tx |=> txe);

  // R3: a completed byte leaves the receive flag set
  a_r3_done_sets_rxf: assert property (@(posedge clk) disable iff (!rst_n)
    ev_rx |=> rxf);

  // R7: completion on a full buffer raises overrun
  a_r7_overrun_set: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_rx && rxf) |=> ovr);

  // R6: chained transfer keeps the slave selected
  a_r6_cs_held: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_rx && ev_tx) |=> !cs_n);

  // R4: serial clock idles low while deselected
  a_r4_idle_sclk_low: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |-> !sclk);

  // R9: a completion with its enable set pulses irq
  a_r9_rx_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_rx && rie) |=> irq);
endmodule

bind spi_irq_master spi_irq_checker chk_i (
  .clk(clk), .rst_n(rst_n), .irq(irq), .cs_n(spi_cs_n), .sclk(spi_sclk),
  .ev_tx(ev_tx_set), .ev_rx(ev_rx_set), .txe(st_txe), .rxf(st_rxf),
  .ovr(st_ovr), .tie(ctl_tie), .rie(ctl_rie)
);

// File: tb/spi_irq_master_tb.sv
`timescale 1ns/1ps
module spi_irq_master_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] reg_addr = 2'd0;
  logic       reg_wr = 1'b0, reg_rd = 1'b0;
  logic [7:0] reg_wdata = 8'h00;
  logic [7:0] reg_rdata;
  logic       spi_sclk, spi_mosi, spi_cs_n, irq;
  logic       spi_miso = 1'b0;

  int n_chk = 0, n_err = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  spi_irq_master dut_i (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .reg_rd(reg_rd), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .spi_sclk(spi_sclk), .spi_mosi(spi_mosi), .spi_miso(spi_miso),
    .spi_cs_n(spi_cs_n), .irq(irq)
  );

  // slave model and monitors, evaluated at the falling system clock edge
  logic [7:0] slave_src [4];
  logic [7:0] cap [4];
  int   cap_n = 0, sl_idx = 0, s_bits = 0;
  logic [7:0] s_sh = 8'h00, s_cap = 8'h00;
  logic sclk_d = 1'b0, cs_d = 1'b1;
  int   cyc = 0, last_rise = 0, min_int = 0, max_int = 0, irq_cnt = 0, cs_rises = 0;
  bit   lr_valid = 0;

  always @(negedge clk) begin
    cyc++;
    if (irq) irq_cnt++;
    if (spi_cs_n && !cs_d) cs_rises++;
    if (!spi_cs_n && cs_d) begin
      s_sh = slave_src[sl_idx[1:0]];
      spi_miso = s_sh[7];
      s_bits = 0;
      lr_valid = 0;
    end
    if (spi_sclk && !sclk_d && !spi_cs_n) begin
      s_cap = {s_cap[6:0], spi_mosi};
      if (lr_valid) begin
        if (cyc - last_rise < min_int) min_int = cyc - last_rise;
        if (cyc - last_rise > max_int) max_int = cyc - last_rise;
      end
      last_rise = cyc;
      lr_valid = 1;
    end
    if (!spi_sclk && sclk_d && !cs_d) begin
      s_bits++;
      if (s_bits == 8) begin
        cap[cap_n[1:0]] = s_cap;
        cap_n++;
        s_bits = 0;
        sl_idx++;
        s_sh = slave_src[sl_idx[1:0]];
      end else begin
        s_sh = {s_sh[6:0], 1'b0};
      end
      spi_miso = s_sh[7];
    end
    sclk_d = spi_sclk;
    cs_d = spi_cs_n;
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr_reg(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); #1;
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk); #1;
    reg_wr = 1'b0; reg_addr = 2'd0;
  endtask

  task automatic rd_reg(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk); #1;
    reg_addr = a; reg_rd = 1'b1;
    #0.5 d = reg_rdata;
    @(negedge clk); #1;
    reg_rd = 1'b0; reg_addr = 2'd0;
  endtask

  task automatic peek_status(output logic [7:0] d);
    reg_addr = 2'd0;
    #0.2 d = reg_rdata;
  endtask

  task automatic prep(input logic [7:0] s0, input logic [7:0] s1);
    slave_src[0] = s0; slave_src[1] = s1; slave_src[2] = 8'h00; slave_src[3] = 8'h00;
    sl_idx = 0; cap_n = 0; min_int = 1000; max_int = 0;
  endtask

  task automatic wait_words(input int n);
    while (cap_n < n) begin @(negedge clk); #1; end
    while (!spi_cs_n) begin @(negedge clk); #1; end
    repeat (2) @(negedge clk);
    #1;
  endtask

  task automatic t_reset();
    logic [7:0] d;
    rd_reg(2'd0, d); check("R1 status", d, 8'h01);
    rd_reg(2'd3, d); check("R1 control", d, 8'h00);
    check("R1 irq", irq, 1'b0);
    check("R1 cs_n", spi_cs_n, 1'b1);
    check("R1 sclk", spi_sclk, 1'b0);
  endtask

  task automatic t_single();
    logic [7:0] d;
    int c0;
    wr_reg(2'd3, 8'h13);   // tx enable only, divider 3
    prep(8'h96, 8'h00);
    c0 = irq_cnt;
    wr_reg(2'd1, 8'hA5);
    peek_status(d); check("R2 txe cleared by write", d[0], 1'b0);
    @(negedge clk); #1;
    peek_status(d); check("R2 txe set on load", d[0], 1'b1);
    check("R2 cs_n low", spi_cs_n, 1'b0);
    check("R8 pulse on load", irq, 1'b1);
    @(negedge clk); #1;
    check("R8 pulse width", irq, 1'b0);
    wait_words(1);
    check("R4 slave captured", cap[0], 8'hA5);
    check("R5 period div3 min", min_int, 8);
    check("R5 period div3 max", max_int, 8);
    check("R9 no rx pulse when disabled", irq_cnt - c0, 1);
    peek_status(d); check("R3 rxf set", d[1], 1'b1);
    rd_reg(2'd2, d); check("R3 rx data", d, 8'h96);
    rd_reg(2'd0, d); check("R3 rxf cleared", d[1], 1'b0);
  endtask

  task automatic t_rx_enable();
    logic [7:0] d;
    int c0;
    wr_reg(2'd3, 8'h20);   // rx enable only, divider 0
    prep(8'h3C, 8'h00);
    c0 = irq_cnt;
    wr_reg(2'd1, 8'h5A);
    wait_words(1);
    check("R4 slave captured", cap[0], 8'h5A);
    check("R5 period div0", max_int, 2);
    check("R9 one rx pulse", irq_cnt - c0, 1);
    rd_reg(2'd2, d); check("R3 rx data", d, 8'h3C);
  endtask

  task automatic t_disabled();
    int c0;
    logic [7:0] d;
    wr_reg(2'd3, 8'h01);
    prep(8'h81, 8'h00);
    c0 = irq_cnt;
    wr_reg(2'd1, 8'h7E);
    wait_words(1);
    check("R8 R9 no pulses disabled", irq_cnt - c0, 0);
    rd_reg(2'd2, d); check("R4 msb-first rx", d, 8'h81);
  endtask

  task automatic t_overrun();
    logic [7:0] d;
    wr_reg(2'd3, 8'h00);
    prep(8'h11, 8'h00);
    wr_reg(2'd1, 8'h01);
    wait_words(1);
    prep(8'h22, 8'h00);
    wr_reg(2'd1, 8'h02);
    wait_words(1);
    rd_reg(2'd0, d); check("R7 overrun set", d, 8'h07);
    wr_reg(2'd0, 8'h00);
    rd_reg(2'd0, d); check("R7 write 0 keeps overrun", d[2], 1'b1);
    wr_reg(2'd0, 8'h04);
    rd_reg(2'd0, d); check("R7 write 1 clears overrun", d[2], 1'b0);
    rd_reg(2'd2, d); check("R7 buffer overwritten", d, 8'h22);
  endtask

  task automatic t_simul();
    logic [7:0] d;
    int c0, r0;
    wr_reg(2'd3, 8'h31);   // both enables, divider 1
    prep(8'hC3, 8'h4B);
    c0 = irq_cnt; r0 = cs_rises;
    wr_reg(2'd1, 8'hE7);
    while (spi_cs_n) begin @(negedge clk); #1; end
    wr_reg(2'd1, 8'h18);
    while (cap_n < 1) begin @(negedge clk); #1; end
    check("R10 irq at coincidence", irq, 1'b1);
    peek_status(d); check("R10 both flags", d[1:0], 2'b11);
    check("R10 pulses so far", irq_cnt - c0, 2);
    @(negedge clk); #1;
    check("R10 single cycle", irq, 1'b0);
    rd_reg(2'd2, d); check("R3 first rx", d, 8'hC3);
    wait_words(2);
    check("R6 first byte out", cap[0], 8'hE7);
    check("R6 second byte out", cap[1], 8'h18);
    check("R6 no idle gap", max_int, 4);
    check("R6 min gap", min_int, 4);
    check("R6 cs held", cs_rises - r0, 1);
    check("R10 total pulses", irq_cnt - c0, 3);
    rd_reg(2'd0, d); check("R6 status after stream", d, 8'h03);
    rd_reg(2'd2, d); check("R3 second rx", d, 8'h4B);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_single();
    t_rx_enable();
    t_disabled();
    t_overrun();
    t_simul();
    finished = 1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_err++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end
endmodule